// File: doc/BRIEF.md
# Palette DAC Hidden Register Access Unit

This block sits on the host side of a palette DAC. It decodes a small set of direct byte ports (palette write index, palette data, pixel mask, palette read index) and keeps a bank of six indirect registers out of sight behind the pixel-mask port. Software reaches the hidden bank by reading the pixel-mask port several times in a row. Once the run is long enough, each further read of that port returns the next indirect register, and a write to that port lands in the register currently selected. Any other kind of access puts the port back to its plain pixel-mask meaning.

The indirect bank holds a writable control register, two fixed identification bytes and three signature bytes. The signature bytes are fed from input pins, which stand in for the compression logic. Three control pins come from the control register: power-down, clock-doubled two-byte pixel input, and 8-bit colour width. The host port is a plain strobed register bus and not a stream, so it has no valid/ready back-pressure. A strobe is taken in the cycle it is high, read data is combinational and valid while the read strobe is high, and every access completes in one cycle.

Top module: `dac_hidden_regs`

## Requirements
- R1: After reset the pixel mask is 0xFF, both palette indexes are 0, the control register is 0 (all three control pins low), and the first pixel-mask read returns 0xFF.
- R2: Port select encoding is 0 = palette write index, 1 = palette data, 2 = pixel mask, 3 = palette read index, 4..7 = unused. From a cleared state, four consecutive pixel-mask reads return the pixel mask. The fifth read returns indirect index 0 (control register), and the reads after it return index 1 (MFG_ID), 2 (DEV_ID), 3 (red signature), 4 (green signature) and 5 (blue signature), in that order.
- R3: The read that follows index 5 returns the pixel mask and restarts the count, so four more pixel-mask reads follow before index 0 comes back.
- R4: A write to any port while the bank is not armed clears the read count. A write to port 2 while not armed updates the pixel mask.
- R5: A read of any port other than 2 clears the read count, including an armed one. Ports 1 and 4..7 read as 0.
- R6: While armed, a write to port 2 stores into the selected indirect register, leaves the pixel mask unchanged, and keeps the bank armed with the same pointer. Only index 0 is writable.
- R7: Writes to indirect indices 1..5 are ignored: those registers and the control register keep their values.
- R8: The power-down pin is control bit 2, the clock-doubled two-byte input pin is bit 5, and the 8-bit colour pin is bit 1. All three follow a control-register write from the next cycle, so a single write can wake the device and set the mode together.
- R9: Ports 0 and 3 are read/write byte registers whose values drive the palette write-index and read-index outputs.
- R10: When read and write strobes are high in the same cycle, the access is handled as a write only.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_sel | input | 3 | Port select |
| bus_rd | input | 1 | Read strobe |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, valid while bus_rd is high, else 0 |
| sig_red | input | 8 | Red signature value |
| sig_grn | input | 8 | Green signature value |
| sig_blu | input | 8 | Blue signature value |
| pix_mask | output | 8 | Current pixel mask |
| pal_wr_index | output | 8 | Palette write index |
| pal_rd_index | output | 8 | Palette read index |
| pwr_down | output | 1 | Power-down request (control bit 2) |
| clk2x_mode | output | 1 | Two-byte input with clock doubler (control bit 5) |
| color8_sel | output | 1 | 8-bit colour values (control bit 1) |

## Verification
The hardest state to reach is a half-built or fully armed unlock run that is then broken by an unrelated access. The count is invisible at the ports, so its value can only be inferred from how many later pixel-mask reads pass before index 0 appears. The bench builds runs of every length up to armed with a given pointer, interrupts them with each port's read and write, and then counts the reads again. The control register is swept over all 256 values through the armed write path. Each value is read back through the same hidden path.

// File: rtl/dac_hidden_pkg.sv
package dac_hidden_pkg;
  localparam int DW = 8;
  localparam int NUM_IND = 6;
  localparam logic [2:0] PORT_WADDR = 3'd0;
  localparam logic [2:0] PORT_DATA  = 3'd1;
  localparam logic [2:0] PORT_PMASK = 3'd2;
  localparam logic [2:0] PORT_RADDR = 3'd3;
  localparam int CTL_COL8_BIT  = 1;
  localparam int CTL_SLEEP_BIT = 2;
  localparam int CTL_DBL_BIT   = 5;
endpackage

// File: rtl/dac_unlock_seq.sv
module dac_unlock_seq #(
  parameter int UNLOCK_READS = 4,
  parameter int NUM_IND = 6,
  localparam int CW = $clog2(UNLOCK_READS + 1),
  localparam int PW = $clog2(NUM_IND)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          acc_rd,
  input  logic          acc_wr,
  input  logic          on_pmask,
  output logic          armed,
  output logic [PW-1:0] ptr
);
  localparam logic [CW-1:0] ARM_VAL = CW'(UNLOCK_READS);
  localparam logic [PW-1:0] LAST = PW'(NUM_IND - 1);

  logic [CW-1:0] cnt;

  assign armed = (cnt == ARM_VAL);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '0;
      ptr <= '0;
    end else if (acc_wr) begin
      if (!(on_pmask && armed)) begin
        cnt <= '0;
        ptr <= '0;
      end
    end else if (acc_rd) begin
      if (!on_pmask) begin
        cnt <= '0;
        ptr <= '0;
      end else if (!armed) begin
        cnt <= cnt + CW'(1);
        ptr <= '0;
      end else if (ptr == LAST) begin
        cnt <= '0;
        ptr <= '0;
      end else begin
        ptr <= ptr + PW'(1);
      end
    end
  end

  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (rst) cnt <= ARM_VAL); // R2
  AST_PTR_RANGE: assert property (@(posedge clk) disable iff (rst) armed |-> ptr <= LAST); // R2
  AST_WR_CLEARS: assert property (@(posedge clk) disable iff (rst)
    (acc_wr && !(on_pmask && armed)) |=> !armed); // R4
  AST_OTHER_RD_CLEARS: assert property (@(posedge clk) disable iff (rst)
    (acc_rd && !on_pmask) |=> (cnt == '0)); // R5
  AST_ARMED_WR_HOLDS: assert property (@(posedge clk) disable iff (rst)
    (acc_wr && on_pmask && armed) |=> (armed && $stable(ptr))); // R6
endmodule

// File: rtl/dac_ind_bank.sv
module dac_ind_bank
  import dac_hidden_pkg::*;
#(
  parameter logic [DW-1:0] MFG_ID = 8'hA5,
  parameter logic [DW-1:0] DEV_ID = 8'h3C,
  localparam int PW = $clog2(NUM_IND)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en,
  input  logic [PW-1:0] idx,
  input  logic [DW-1:0] wdata,
  input  logic [DW-1:0] sig_red,
  input  logic [DW-1:0] sig_grn,
  input  logic [DW-1:0] sig_blu,
  output logic [DW-1:0] ctl_reg,
  output logic [DW-1:0] rdata
);
  logic [DW-1:0] view [NUM_IND];

  always_ff @(posedge clk) begin
    if (rst) ctl_reg <= '0;
    else if (wr_en && idx == '0) ctl_reg <= wdata;
  end

  always_comb begin
    view[0] = ctl_reg;
    view[1] = MFG_ID;
    view[2] = DEV_ID;
    view[3] = sig_red;
    view[4] = sig_grn;
    view[5] = sig_blu;
  end

  assign rdata = (idx < PW'(NUM_IND)) ? view[idx] : '0;

  AST_RO_IGNORED: assert property (@(posedge clk) disable iff (rst)
    (wr_en && idx != '0) |=> $stable(ctl_reg)); // R7
  AST_CTL_STORE: assert property (@(posedge clk) disable iff (rst)
    (wr_en && idx == '0) |=> (ctl_reg == $past(wdata))); // R6
endmodule

// File: rtl/dac_direct_regs.sv
module dac_direct_regs
  import dac_hidden_pkg::*;
(
  input  logic          clk,
  input  logic          rst,
  input  logic          wr,
  input  logic          mask_lock,
  input  logic [2:0]    sel,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] pmask,
  output logic [DW-1:0] waddr,
  output logic [DW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  always_ff @(posedge clk) begin
    if (rst) begin
      pmask <= '1;
      waddr <= '0;
      raddr <= '0;
    end else if (wr) begin
      case (sel)
        PORT_WADDR: waddr <= wdata;
        PORT_RADDR: raddr <= wdata;
        PORT_PMASK: if (!mask_lock) pmask <= wdata;
        default: ;
      endcase
    end
  end

  always_comb begin
    case (sel)
      PORT_WADDR: rdata = waddr;
      PORT_RADDR: rdata = raddr;
      PORT_PMASK: rdata = pmask;
      default:    rdata = '0;
    endcase
  end

  AST_MASK_LOCKED: assert property (@(posedge clk) disable iff (rst)
    (wr && mask_lock) |=> $stable(pmask)); // R6
endmodule

// File: rtl/dac_hidden_regs.sv
module dac_hidden_regs
  import dac_hidden_pkg::*;
#(
  parameter int UNLOCK_READS = 4,
  parameter logic [7:0] MFG_ID = 8'hA5,
  parameter logic [7:0] DEV_ID = 8'h3C
) (
  input  logic       clk,
  input  logic       rst,
  input  logic [2:0] bus_sel,
  input  logic       bus_rd,
  input  logic       bus_wr,
  input  logic [7:0] bus_wdata,
  output logic [7:0] bus_rdata,
  input  logic [7:0] sig_red,
  input  logic [7:0] sig_grn,
  input  logic [7:0] sig_blu,
  output logic [7:0] pix_mask,
  output logic [7:0] pal_wr_index,
  output logic [7:0] pal_rd_index,
  output logic       pwr_down,
  output logic       clk2x_mode,
  output logic       color8_sel
);
  localparam int PW = $clog2(NUM_IND);

  logic          acc_rd, on_pmask, armed;
  logic [PW-1:0] ptr;
  logic [DW-1:0] ctl_reg, bank_rdata, direct_rdata;

  assign acc_rd   = bus_rd && !bus_wr;
  assign on_pmask = (bus_sel == PORT_PMASK);

  dac_unlock_seq #(.UNLOCK_READS(UNLOCK_READS), .NUM_IND(NUM_IND)) u_seq (
    .clk(clk), .rst(rst), .acc_rd(acc_rd), .acc_wr(bus_wr),
    .on_pmask(on_pmask), .armed(armed), .ptr(ptr)
  );

  dac_ind_bank #(.MFG_ID(MFG_ID), .DEV_ID(DEV_ID)) u_bank (
    .clk(clk), .rst(rst), .wr_en(bus_wr && on_pmask && armed), .idx(ptr),
    .wdata(bus_wdata), .sig_red(sig_red), .sig_grn(sig_grn), .sig_blu(sig_blu),
    .ctl_reg(ctl_reg), .rdata(bank_rdata)
  );

  dac_direct_regs u_direct (
    .clk(clk), .rst(rst), .wr(bus_wr), .mask_lock(armed), .sel(bus_sel),
    .wdata(bus_wdata), .pmask(pix_mask), .waddr(pal_wr_index),
    .raddr(pal_rd_index), .rdata(direct_rdata)
  );

  always_comb begin
    if (!acc_rd)                bus_rdata = '0;
    else if (on_pmask && armed) bus_rdata = bank_rdata;
    else                        bus_rdata = direct_rdata;
  end

  assign pwr_down   = ctl_reg[CTL_SLEEP_BIT];
  assign clk2x_mode = ctl_reg[CTL_DBL_BIT];
  assign color8_sel = ctl_reg[CTL_COL8_BIT];

  AST_ARMED_MASK_KEPT: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && on_pmask && armed) |=> $stable(pix_mask)); // R6
  AST_IDLE_RDATA: assert property (@(posedge clk) disable iff (rst)
    !acc_rd |-> (bus_rdata == '0)); // R10
endmodule

// File: tb/dac_hidden_regs_bench.sv
module dac_hidden_regs_bench;
  localparam logic [7:0] MFG = 8'hA5;
  localparam logic [7:0] DEV = 8'h3C;
  localparam logic [7:0] SR = 8'h11, SG = 8'h22, SB = 8'h33;

  logic clk = 0, rst = 1;
  logic [2:0] bus_sel = 0;
  logic bus_rd = 0, bus_wr = 0;
  logic [7:0] bus_wdata = 0, bus_rdata;
  logic [7:0] pix_mask, pal_wr_index, pal_rd_index;
  logic pwr_down, clk2x_mode, color8_sel;

  int checks = 0, fails = 0;
  bit done = 0;
  logic [7:0] exp_pm = 8'hFF, exp_ctl = 0, exp_wa = 0, exp_ra = 0;

  always #5 clk = ~clk;

  dac_hidden_regs #(.UNLOCK_READS(4), .MFG_ID(MFG), .DEV_ID(DEV)) u_dac_hidden_regs (
    .clk(clk), .rst(rst), .bus_sel(bus_sel), .bus_rd(bus_rd), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .sig_red(SR), .sig_grn(SG),
    .sig_blu(SB), .pix_mask(pix_mask), .pal_wr_index(pal_wr_index),
    .pal_rd_index(pal_rd_index), .pwr_down(pwr_down), .clk2x_mode(clk2x_mode),
    .color8_sel(color8_sel)
  );

  task automatic check(input string req, input logic [7:0] got, input logic [7:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %02h expected %02h", req, got, exp);
    end
  endtask

  function automatic logic [7:0] ind_val(input int i);
    case (i)
      0: return exp_ctl;
      1: return MFG;
      2: return DEV;
      3: return SR;
      4: return SG;
      default: return SB;
    endcase
  endfunction

  function automatic logic [7:0] port_val(input int s);
    case (s)
      0: return exp_wa;
      2: return exp_pm;
      3: return exp_ra;
      default: return 8'h00;
    endcase
  endfunction

  task automatic access(input logic [2:0] s, input logic r, input logic w,
                        input logic [7:0] d, output logic [7:0] q);
    @(negedge clk);
    bus_sel = s; bus_rd = r; bus_wr = w; bus_wdata = d;
    #1 q = bus_rdata;
    @(posedge clk);
    #1 bus_rd = 0; bus_wr = 0;
  endtask

  task automatic rd(input logic [2:0] s, output logic [7:0] q);
    access(s, 1'b1, 1'b0, 8'h00, q);
  endtask

  task automatic wr(input logic [2:0] s, input logic [7:0] d);
    logic [7:0] q;
    access(s, 1'b0, 1'b1, d, q);
    if (s == 3'd0) exp_wa = d;
    if (s == 3'd3) exp_ra = d;
  endtask

  task automatic clear_seq();
    logic [7:0] q;
    rd(3'd0, q);
  endtask

  task automatic pm_reads(input int n, input string req);
    logic [7:0] q;
    for (int i = 0; i < n; i++) begin
      rd(3'd2, q);
      check(req, q, exp_pm);
    end
  endtask

  task automatic ctl_pins(input string req);
    check(req, {5'b0, pwr_down, clk2x_mode, color8_sel},
          {5'b0, exp_ctl[2], exp_ctl[5], exp_ctl[1]});
  endtask

  initial begin
    repeat (2000000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [7:0] q;
    repeat (3) @(posedge clk);
    #1 rst = 0;
    // R1 reset state
    check("R1 pix_mask", pix_mask, 8'hFF);
    check("R1 wr index", pal_wr_index, 8'h00);
    check("R1 rd index", pal_rd_index, 8'h00);
    ctl_pins("R1 control pins");
    rd(3'd2, q); check("R1 first mask read", q, 8'hFF);
    clear_seq();

    // R4 unarmed mask write, then R2 full walk, R3 wrap
    wr(3'd2, 8'h5A); exp_pm = 8'h5A;
    check("R4 mask written", pix_mask, exp_pm);
    pm_reads(4, "R2 unlock read");
    for (int i = 0; i < 6; i++) begin
      rd(3'd2, q); check($sformatf("R2 index %0d", i), q, ind_val(i));
    end
    pm_reads(1, "R3 read after last index");
    pm_reads(3, "R3 recount");
    rd(3'd2, q); check("R3 index 0 returns", q, ind_val(0));
    clear_seq();

    // R5: other-port reads clear a partial and an armed run
    for (int s = 0; s < 8; s++) begin
      if (s == 2) continue;
      pm_reads(3, "R5 partial run");
      rd(3'(s), q); check($sformatf("R5 port %0d read", s), q, port_val(s));
      pm_reads(4, "R5 count restarted");
      rd(3'd2, q); check("R5 index 0 after restart", q, ind_val(0));
      rd(3'd2, q); check("R5 index 1", q, ind_val(1));
      rd(3'(s), q);
      pm_reads(4, "R5 armed run broken");
      clear_seq();
    end

    // R4: writes to other ports clear an armed run; R9 index regs
    for (int s = 0; s < 8; s++) begin
      if (s == 2) continue;
      pm_reads(4, "R4 arm");
      rd(3'd2, q); check("R4 index 0", q, ind_val(0));
      wr(3'(s), 8'(8'h40 + s));
      check("R9 wr index out", pal_wr_index, exp_wa);
      check("R9 rd index out", pal_rd_index, exp_ra);
      pm_reads(4, "R4 count cleared by write");
      rd(3'd2, q); check("R4 index 0 after clear", q, ind_val(0));
      clear_seq();
    end
    pm_reads(2, "R4 partial");
    wr(3'd2, 8'hC3); exp_pm = 8'hC3;
    check("R4 mask update", pix_mask, exp_pm);
    pm_reads(4, "R4 restarted by mask write");
    rd(3'd2, q); check("R4 index 0 after mask write", q, ind_val(0));
    clear_seq();

    // R6/R8: sweep the control register through the armed write path
    for (int v = 0; v < 256; v++) begin
      pm_reads(4, "R6 arm");
      wr(3'd2, 8'(v)); exp_ctl = 8'(v);
      check("R6 mask untouched", pix_mask, exp_pm);
      ctl_pins("R8 control pins");
      rd(3'd2, q); check("R6 readback same pointer", q, exp_ctl);
      clear_seq();
    end

    // R7: read-only indices ignore writes
    exp_ctl = 8'h26;
    pm_reads(4, "R7 arm"); wr(3'd2, exp_ctl); clear_seq();
    for (int i = 1; i < 6; i++) begin
      pm_reads(4, "R7 arm");
      for (int k = 0; k < i; k++) rd(3'd2, q);
      wr(3'd2, ~ind_val(i));
      ctl_pins("R7 control unchanged");
      check("R7 mask unchanged", pix_mask, exp_pm);
      clear_seq();
      pm_reads(4, "R7 rearm");
      for (int k = 0; k < 6; k++) begin
        rd(3'd2, q); check($sformatf("R7 index %0d kept", k), q, ind_val(k));
      end
      clear_seq();
    end

    // R10: simultaneous strobes act as a write
    pm_reads(4, "R10 arm");
    access(3'd0, 1'b1, 1'b1, 8'h77, q); exp_wa = 8'h77;
    check("R10 write taken", pal_wr_index, exp_wa);
    check("R10 no read data", q, 8'h00);
    pm_reads(4, "R10 count cleared");
    clear_seq();

    // R9: index register sweep
    for (int v = 0; v < 256; v += 3) begin
      wr(3'd0, 8'(v)); wr(3'd3, ~8'(v));
      check("R9 wr index pin", pal_wr_index, 8'(v));
      check("R9 rd index pin", pal_rd_index, ~8'(v));
      rd(3'd0, q); check("R9 wr index read", q, 8'(v));
      rd(3'd3, q); check("R9 rd index read", q, ~8'(v));
    end

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule